// File: doc/BRIEF.md
# Lookup-Table Logic Trigger

This block decides, sample by sample, whether a 16-channel logic capture has reached its trigger condition. In the table-driven mode the probes are cut into four groups of four. The 4-bit value of each group addresses a 16-bit truth table for that group. A condition is true only when all four group tables return 1. Three such table sets exist. The first is a value/mask comparator. The other two each pick out one monitored signal for edge detection.

A 16-entry glue table looks at the previous and current values of the two monitored signals and turns them into an edge condition. A final 16-entry table then merges the comparator result with the edge result into one trigger decision. A separate fast mode ignores the tables and fires on a rising or falling edge of one pin, chosen among probes 0 to 7.

Software programs all tables one row at a time through a staging word and a select write. The trigger comes out as a one-cycle registered pulse. A sticky flag records that the trigger has fired and keeps that record until the next arm command.

Top module: `lut_trigger_unit`

## Requirements
- R1: After reset, `trig` and `trig_seen` are 0 and every table holds all zeros, so no sample can fire the trigger until tables are loaded.
- R2: Probe group q is `probes[4q+3:4q]`. Its 4-bit value indexes bit q of the value/mask table set. The match term is 1 only when all four addressed bits are 1.
- R3: Monitored signal n (n = 0, 1) is the AND of the four group lookups in edge-select table set n.
- R4: The glue table index has the current value of signal n in bit 2n and its value at the previous sample in bit 2n+1. The previous values, including the fast-mode pin history, update only on cycles with `smp_en` high.
- R5: The final table index is {match, glue output, secondary output, 1} from bit 3 down to bit 0, where the secondary table is addressed like the glue table. With the final table at 0xA000 the trigger equals match AND glue.
- R6: Row i is written to every table by a select write (`sel_we`) whose value is 0x30|i. The staged row word maps as follows: bits 3:0 go to value/mask groups 0..3. Bits 4, 5 and 6 go to glue, secondary and final. Bits 11:8 go to edge set 0, groups 0..3, and bits 15:12 go to edge set 1, groups 0..3. A select write whose upper nibble is not 3 changes no table.
- R7: `trig` is high for exactly the one cycle after a clock edge at which `smp_en` was high and the condition held. It is never high otherwise.
- R8: With `fast_mode` high, `fast_sel[2:0]` names a pin 0..7. `fast_sel[3]`=1 fires on that pin going 1 to 0 between samples, and `fast_sel[3]`=0 fires on it going 0 to 1. Other pins have no effect.
- R9: `trig_seen` goes high with the first `trig` pulse and stays high until `arm` is sampled high, which clears it. Arm wins over a trigger in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smp_en | input | 1 | Marks a cycle that carries a new sample |
| probes | input | 16 | Probe sample |
| fast_mode | input | 1 | 1 selects the single-pin edge trigger |
| fast_sel | input | 4 | Fast mode: pin in [2:0], falling edge when [3] is 1 |
| arm | input | 1 | Clears the sticky flag |
| row_data | input | 16 | Staged table row |
| sel_we | input | 1 | Select write strobe |
| sel_val | input | 8 | Select value; 0x30|i commits row i |
| trig | output | 1 | One-cycle trigger pulse |
| trig_seen | output | 1 | Sticky trigger flag |

## Verification
The bench checks that edges are judged only against the previous sampled value. A design that updated its history on idle cycles would miss a falling edge after the probes moved between samples. It checks that a level that holds for two samples fires only once. A glue index with swapped current and previous bits would fire on the wrong edge direction or on a held level, and the bench tests both directions. It also sends a select value outside the commit range, which a loose decoder would accept and use to wipe the glue table. In fast mode it toggles pins other than the selected one, and it flips the polarity bit with the pin held, so that a design which watched the wrong pin or inverted the polarity would fire where none is expected.

// File: rtl/lut_trigger_unit.sv
module lut_trigger_unit #(
  parameter int NPROBE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic [NPROBE-1:0] probes,
  input  logic              fast_mode,
  input  logic [3:0]        fast_sel,
  input  logic              arm,
  input  logic [15:0]       row_data,
  input  logic              sel_we,
  input  logic [7:0]        sel_val,
  output logic              trig,
  output logic              trig_seen
);
  localparam int NQ = NPROBE / 4;

  logic [15:0] vm_t [NQ];
  logic [15:0] e0_t [NQ];
  logic [15:0] e1_t [NQ];
  logic [15:0] glue_t, sec_t, fin_t;
  logic [7:0]  prev_lo;
  logic        prev0, prev1;
  logic        vm_ok, mon0, mon1;

  wire       commit = sel_we && (sel_val[7:4] == 4'h3);
  wire [3:0] ri     = sel_val[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        vm_t[q] <= '0;
        e0_t[q] <= '0;
        e1_t[q] <= '0;
      end
      glue_t <= '0;
      sec_t  <= '0;
      fin_t  <= '0;
    end else if (commit) begin
      for (int q = 0; q < NQ; q++) begin
        vm_t[q][ri] <= row_data[q];
        e0_t[q][ri] <= row_data[8+q];
        e1_t[q][ri] <= row_data[12+q];
      end
      glue_t[ri] <= row_data[4];
      sec_t[ri]  <= row_data[5];
      fin_t[ri]  <= row_data[6];
    end
  end

  always_comb begin
    vm_ok = 1'b1;
    mon0  = 1'b1;
    mon1  = 1'b1;
    for (int q = 0; q < NQ; q++) begin
      vm_ok = vm_ok & vm_t[q][probes[4*q +: 4]];
      mon0  = mon0  & e0_t[q][probes[4*q +: 4]];
      mon1  = mon1  & e1_t[q][probes[4*q +: 4]];
    end
  end

  wire [3:0] gidx      = {prev1, mon1, prev0, mon0};
  wire [3:0] fidx      = {vm_ok, glue_t[gidx], sec_t[gidx], 1'b1};
  wire       basic_hit = fin_t[fidx];

  wire pin_now  = probes[fast_sel[2:0]];
  wire pin_prev = prev_lo[fast_sel[2:0]];
  wire fast_hit = fast_sel[3] ? (pin_prev & ~pin_now) : (~pin_prev & pin_now);

  wire fire = smp_en & (fast_mode ? fast_hit : basic_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev0     <= 1'b0;
      prev1     <= 1'b0;
      prev_lo   <= '0;
      trig      <= 1'b0;
      trig_seen <= 1'b0;
    end else begin
      if (smp_en) begin
        prev0   <= mon0;
        prev1   <= mon1;
        prev_lo <= probes[7:0];
      end
      trig      <= fire;
      trig_seen <= arm ? 1'b0 : (trig_seen | fire);
    end
  end
endmodule

// File: rtl/lut_trigger_chk.sv
module lut_trigger_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        smp_en,
  input logic [15:0] probes,
  input logic        fast_mode,
  input logic [3:0]  fast_sel,
  input logic        arm,
  input logic        trig,
  input logic        trig_seen
);
  p_no_sample_no_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> !trig);

  p_pulse_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !$past(arm)) |-> trig_seen);

  p_arm_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !trig_seen);

  p_flag_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_seen && !arm) |=> trig_seen);

  p_fast_rise_needs_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && fast_mode && !fast_sel[3] && !probes[fast_sel[2:0]]) |=> !trig);

  p_fast_fall_needs_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && fast_mode && fast_sel[3] && probes[fast_sel[2:0]]) |=> !trig);
endmodule

bind lut_trigger_unit lut_trigger_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .probes(probes),
  .fast_mode(fast_mode), .fast_sel(fast_sel), .arm(arm),
  .trig(trig), .trig_seen(trig_seen)
);

// File: tb/sim_lut_trigger_unit.sv
module sim_lut_trigger_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_en = 1'b0;
  logic [15:0] probes = '0;
  logic        fast_mode = 1'b0;
  logic [3:0]  fast_sel = '0;
  logic        arm = 1'b0;
  logic [15:0] row_data = '0;
  logic        sel_we = 1'b0;
  logic [7:0]  sel_val = '0;
  logic        trig, trig_seen;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lut_trigger_unit u0 (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .probes(probes),
    .fast_mode(fast_mode), .fast_sel(fast_sel), .arm(arm),
    .row_data(row_data), .sel_we(sel_we), .sel_val(sel_val),
    .trig(trig), .trig_seen(trig_seen)
  );

  // vector: {cfg, probe sample, expected trig}
  localparam int NV = 13;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 16'h0000, 1'b0},
    {1'b0, 16'h0250, 1'b1},
    {1'b0, 16'h0250, 1'b0},
    {1'b0, 16'h0050, 1'b0},
    {1'b0, 16'h0200, 1'b0},
    {1'b0, 16'h0000, 1'b0},
    {1'b0, 16'h0350, 1'b1},
    {1'b0, 16'h0270, 1'b0},
    {1'b1, 16'h0001, 1'b0},
    {1'b1, 16'h0000, 1'b1},
    {1'b1, 16'h0000, 1'b0},
    {1'b1, 16'hFFF1, 1'b0},
    {1'b1, 16'hFFF0, 1'b1}
  };

  logic [15:0] t_vm [4], t_e0 [4], t_e1 [4];
  logic [15:0] t_glue, t_sec, t_fin;

  function automatic logic [15:0] quad_tab(input logic [15:0] v, input logic [15:0] m, input int q);
    logic [15:0] r = '0;
    for (int j = 0; j < 16; j++) begin
      logic ok = 1'b1;
      for (int k = 0; k < 4; k++)
        if (m[4*q+k] && (v[4*q+k] != j[k])) ok = 1'b0;
      r[j] = ok;
    end
    return r;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic sel_write(input logic [15:0] d, input logic [7:0] s);
    @(negedge clk);
    row_data = d; sel_val = s; sel_we = 1'b1;
    @(negedge clk);
    sel_we = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < 16; i++) begin
      logic [15:0] d = '0;
      for (int q = 0; q < 4; q++) begin
        d[q]    = t_vm[q][i];
        d[8+q]  = t_e0[q][i];
        d[12+q] = t_e1[q][i];
      end
      d[4] = t_glue[i]; d[5] = t_sec[i]; d[6] = t_fin[i];
      sel_write(d, 8'h30 | 8'(i));
    end
  endtask

  task automatic set_cfg(input logic [15:0] vv, input logic [15:0] vmk,
                         input logic [15:0] e0, input logic [15:0] e1,
                         input logic [15:0] g);
    for (int q = 0; q < 4; q++) begin
      t_vm[q] = quad_tab(vv, vmk, q);
      t_e0[q] = quad_tab(e0, e0, q);
      t_e1[q] = quad_tab(e1, e1, q);
    end
    t_glue = g; t_sec = 16'h0000; t_fin = 16'hA000;
    load_all();
  endtask

  // drive one cycle; trig is sampled just after the edge that registers it
  task automatic step(input logic [15:0] p, input logic en, input logic exp, input string tag);
    @(negedge clk);
    probes = p; smp_en = en;
    @(posedge clk);
    #1;
    check(trig, exp, tag);
    @(negedge clk);
    smp_en = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cur;
    repeat (3) @(negedge clk);
    check(trig, 1'b0, "R1 reset trig");
    check(trig_seen, 1'b0, "R1 reset flag");
    rst_n = 1'b1;
    step(16'h0000, 1'b1, 1'b0, "R1 empty tables");
    step(16'hFFFF, 1'b1, 1'b0, "R1 empty tables");

    // cfg0: match probes[7:4]==5, rising edge on probe 9 (glue 0x2222)
    // cfg1: no match term, falling edge on probe 0 as signal 1 (glue 0x0F00)
    cur = -1;
    for (int v = 0; v < NV; v++) begin
      if (int'(VEC[v][17]) != cur) begin
        cur = int'(VEC[v][17]);
        if (cur == 0) set_cfg(16'h0050, 16'h00F0, 16'h0200, 16'h0000, 16'h2222);
        else          set_cfg(16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'h0F00);
      end
      step(VEC[v][16:1], 1'b1, VEC[v][0], "R2 R3 R4 R5 R7 vector");
    end
    check(trig_seen, 1'b1, "R9 flag after pulse");

    // R4: history moves only with smp_en
    step(16'h0001, 1'b1, 1'b0, "R4 set high");
    step(16'h0000, 1'b0, 1'b0, "R7 no sample no pulse");
    step(16'h0000, 1'b0, 1'b0, "R7 no sample no pulse");
    step(16'h0000, 1'b1, 1'b1, "R4 fall against last sample");

    // R6: select outside 0x3x leaves glue intact
    sel_write(16'h0000, 8'h2B);
    sel_write(16'h0000, 8'h38 ^ 8'h80);
    step(16'h0001, 1'b1, 1'b0, "R6 ignored select");
    step(16'h0000, 1'b1, 1'b1, "R6 ignored select");

    // R9: arm clears, stays clear with no trigger
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    check(trig_seen, 1'b0, "R9 arm clears");
    step(16'h0000, 1'b1, 1'b0, "R9 quiet");
    check(trig_seen, 1'b0, "R9 stays clear");

    // R8: fast mode, pin 3
    fast_mode = 1'b1; fast_sel = 4'b1011;
    step(16'h0008, 1'b1, 1'b0, "R8 rise with falling select");
    step(16'h00F7 ^ 16'h00F0, 1'b1, 1'b1, "R8 falling pin3");
    step(16'h00F0, 1'b1, 1'b0, "R8 other pins ignored");
    step(16'h0008, 1'b1, 1'b0, "R8 rise ignored");
    fast_sel = 4'b0011;
    step(16'h0000, 1'b1, 1'b0, "R8 fall with rising select");
    step(16'h0008, 1'b1, 1'b1, "R8 rising pin3");
    step(16'h0008, 1'b1, 1'b0, "R8 held level");
    check(trig_seen, 1'b1, "R9 fast sets flag");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule